// File: doc/BRIEF.md
# Addressable Bit Latch with Mode Control

This block keeps a bank of output bits, one per address value, and updates them from a single serial data input. Two control inputs choose what happens on each clock. With the active-low enable asserted, the addressed bit takes the data value. The clear input then decides the fate of the other bits: they either keep their stored state or are forced to zero. With enable deasserted, the bank either holds everything or is wiped to zero, again depending on clear.

The level-sensitive behaviour of a classic addressable latch is modelled here as registers sampled on the rising edge of a system clock. Every output updates at the edge where its inputs are sampled. The intended use is to build up a control word bit by bit, or to steer one data line to one of the outputs. The address should be changed only while the bank is holding, so that no intermediate address selects the wrong bit.

Top module: `bit_select_latch`

## Requirements
- R1: A synchronous active-high reset makes every output bit zero at the next rising edge.
- R2: With enableN=0 and clearIn=0 (latch mode), the output bit at index selIn takes the value of dataIn at the rising edge.
- R3: In latch mode, every output bit whose index differs from selIn keeps its previous value.
- R4: With enableN=1 and clearIn=0 (hold mode), all output bits keep their values, whatever dataIn and selIn are.
- R5: With enableN=0 and clearIn=1 (steer mode), the output bit at index selIn takes dataIn and every other output bit becomes zero.
- R6: With enableN=1 and clearIn=1 (clear mode), all output bits become zero.
- R7: selIn is a binary index with bit 0 as least significant, so value n selects output bit n (outBits[n]) and no other bit.
- R8: State written by latch or steer mode persists when the block then enters hold mode, including the zeros that steer mode left in the unselected bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| selIn | input | ADDR_W (3) | Index of the output bit to write |
| dataIn | input | 1 | Value written to the selected bit |
| enableN | input | 1 | Write enable, active low |
| clearIn | input | 1 | Clear control, active high |
| outBits | output | 2**ADDR_W (8) | Stored output bits |

## Verification
The bench builds the block with its default index width of three, giving eight output bits. That keeps every index value reachable many times over in a few hundred random cycles, so every bit sees writes in each of the four modes and every transition between modes. Directed sequences add a one-hot walk across all indices and hold phases entered directly from latch and steer mode.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef enum logic [1:0] {
    MODE_LATCH = 2'b00,
    MODE_STEER = 2'b01,
    MODE_HOLD  = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic writeSel;   // selected bit loads data
    logic keepOthers; // unselected bits hold (else zero)
    logic zeroAll;    // every bit goes to zero
  } strobe_t;

endpackage

// File: rtl/bsl_decode.sv
module bsl_decode #(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]  selIn,
  output logic [NUM_OUT-1:0] hitVec
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
    assign hitVec[i] = (selIn == ADDR_W'(i));
  end

  always_comb begin
    a_r7_onehot_select : assert ($countones(hitVec) == 1);
  end

endmodule

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
(
  input  logic    enableN,
  input  logic    clearIn,
  output strobe_t strobe
);

  mode_t mode;

  assign mode = mode_t'({enableN, clearIn});

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_LATCH: begin strobe.writeSel = 1'b1; strobe.keepOthers = 1'b1; end
      MODE_STEER: begin strobe.writeSel = 1'b1; strobe.keepOthers = 1'b0; end
      MODE_HOLD:  begin strobe.writeSel = 1'b0; strobe.keepOthers = 1'b1; end
      MODE_CLEAR: begin strobe.zeroAll  = 1'b1; end
      default:    strobe = '0;
    endcase
  end

  // R6: clearing never combines with a write
  always_comb begin
    a_r6_clear_excludes_write : assert (!(strobe.zeroAll && strobe.writeSel));
  end

endmodule

// File: rtl/bsl_dp.sv
module bsl_dp
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic [NUM_OUT-1:0] hitVec,
  input  logic               dataIn,
  output logic [NUM_OUT-1:0] bitsQ
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                                bitsQ[i] <= 1'b0;
      else if (strobe.zeroAll)                bitsQ[i] <= 1'b0;
      else if (strobe.writeSel && hitVec[i])  bitsQ[i] <= dataIn;
      else if (!strobe.keepOthers)            bitsQ[i] <= 1'b0;
    end
  end

  // R3: an unselected bit never changes while others are kept
  a_r3_unselected_hold : assert property (@(posedge clk) disable iff (rst)
    (strobe.keepOthers && !strobe.zeroAll) |=>
      ((bitsQ & ~$past(hitVec)) == ($past(bitsQ) & ~$past(hitVec))));

endmodule

// File: rtl/bit_select_latch.sv
module bit_select_latch
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  selIn,
  input  logic               dataIn,
  input  logic               enableN,
  input  logic               clearIn,
  output logic [NUM_OUT-1:0] outBits
);

  strobe_t            strobe;
  logic [NUM_OUT-1:0] hitVec;

  bsl_ctrl u_ctrl (
    .enableN (enableN),
    .clearIn (clearIn),
    .strobe  (strobe)
  );

  bsl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .selIn  (selIn),
    .hitVec (hitVec)
  );

  bsl_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .hitVec (hitVec),
    .dataIn (dataIn),
    .bitsQ  (outBits)
  );

  a_r1_reset_zero : assert property (@(posedge clk)
    rst |=> (outBits == '0));

  a_r2_latch_write : assert property (@(posedge clk) disable iff (rst)
    (!enableN && !clearIn) |=> (outBits[$past(selIn)] == $past(dataIn)));

  a_r4_hold_stable : assert property (@(posedge clk) disable iff (rst)
    (enableN && !clearIn) |=> $stable(outBits));

  a_r5_steer_single : assert property (@(posedge clk) disable iff (rst)
    (!enableN && clearIn) |=>
      (($countones(outBits) <= 1) && (outBits[$past(selIn)] == $past(dataIn))));

  a_r6_clear_all : assert property (@(posedge clk) disable iff (rst)
    (enableN && clearIn) |=> (outBits == '0));

endmodule

// File: tb/sim_bit_select_latch.sv
`timescale 1ns/1ps
module sim_bit_select_latch;

  localparam int AW = 3;
  localparam int NO = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] selIn;
  logic          dataIn;
  logic          enableN;
  logic          clearIn;
  logic [NO-1:0] outBits;

  int runCnt  = 0;
  int failCnt = 0;
  logic [NO-1:0] expBits;

  always #4 clk = ~clk;  // 125 MHz

  bit_select_latch #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .selIn(selIn), .dataIn(dataIn),
    .enableN(enableN), .clearIn(clearIn), .outBits(outBits)
  );

  // Reference of the mode table
  function automatic logic [NO-1:0] refNext(input logic [NO-1:0] prev,
      input logic [AW-1:0] s, input logic d, input logic en, input logic cl);
    logic [NO-1:0] n;
    n = prev;
    if (en && cl)        n = '0;
    else if (!en && cl) begin n = '0; n[s] = d; end
    else if (!en)        n[s] = d;
    return n;
  endfunction

  function automatic string modeTag(input logic en, input logic cl);
    if (en && cl)  return "R6 clear";
    if (!en && cl) return "R5 steer";
    if (!en)       return "R2 R3 latch";
    return "R4 hold";
  endfunction

  task automatic check(input string tag);
    runCnt++;
    if (outBits !== expBits) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", tag, outBits, expBits);
    end
  endtask

  // Called at a falling edge; applies one cycle and checks at the next falling edge
  task automatic step(input logic [AW-1:0] s, input logic d, input logic en,
                      input logic cl, input string tag);
    selIn = s; dataIn = d; enableN = en; clearIn = cl;
    expBits = refNext(expBits, s, d, en, cl);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    runCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005eed));
    rst = 1'b1; selIn = '0; dataIn = 1'b1; enableN = 1'b0; clearIn = 1'b0;
    expBits = '0;
    @(posedge clk); @(negedge clk);
    check("R1 reset");
    rst = 1'b0;

    // R7: one-hot walk, each index sets only its own bit
    for (int i = 0; i < NO; i++) begin
      step('0, 1'b0, 1'b1, 1'b1, "R6 clear before walk");
      step(AW'(i), 1'b1, 1'b0, 1'b0, "R7 index selects own bit");
    end

    // R2/R3: build a pattern
    step('0, 1'b0, 1'b1, 1'b1, "R6 clear");
    for (int i = 0; i < NO; i++)
      step(AW'(i), 1'(i % 2), 1'b0, 1'b0, "R2 R3 build pattern");
    step(3'd1, 1'b0, 1'b0, 1'b0, "R2 overwrite one with zero");

    // R4: hold ignores data and address; R8 hold after latch
    for (int i = 0; i < NO; i++)
      step(AW'(i), 1'(~i[0]), 1'b1, 1'b0, "R4 R8 hold after latch");

    // R5 then R8 hold keeps zeros
    step(3'd6, 1'b1, 1'b0, 1'b1, "R5 steer");
    step(3'd2, 1'b1, 1'b1, 1'b0, "R8 hold after steer");
    step(3'd5, 1'b0, 1'b1, 1'b0, "R8 hold after steer");

    // R6 clear from nonzero
    step(3'd7, 1'b1, 1'b0, 1'b0, "R2 set top bit");
    step(3'd7, 1'b1, 1'b1, 1'b1, "R6 clear");

    // R1 reset from nonzero state
    step(3'd4, 1'b1, 1'b0, 1'b0, "R2 set bit");
    rst = 1'b1; expBits = '0;
    @(posedge clk); @(negedge clk);
    check("R1 reset from nonzero");
    rst = 1'b0;

    // Random mix across all modes and indices
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] s;
      logic d, en, cl;
      s  = AW'($urandom);
      d  = 1'($urandom);
      en = 1'($urandom);
      cl = (($urandom % 4) == 0);
      step(s, d, en, cl, modeTag(en, cl));
    end

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule